// File: doc/BRIEF.md
# Programmable LCD Line/Frame Timing and Gray-Level Generator

This block produces the timing strobes for a monochrome dot-matrix LCD and converts 2-bit pixel codes into 5-step gray levels. A small byte-wide register port sets the block up. One register holds the enable, page, gradation, divider and polarity fields. Another holds the dot width and the horizontal count. The last two hold the active line count and the blanking line count. The input clock is divided by an even factor into a shift-clock enable. That enable is counted into lines and the lines into frames. Sync strobes and a frame interrupt are derived from the counters.

A line lasts (40 or 50 shift clocks) × divider × (horizontal count + 1) input clocks. A frame is the active lines followed by the blanking lines. The timing fields and the page select are held in shadow copies, which reload only at a frame boundary or while the display is off. A frame in progress therefore never changes geometry. The gradation mode and the polarity act at once on the registered gray output.

Top module: `lcd_timing_gen`

## Requirements
- R1: With clock-select code c (control register, address 0, bits 3:1), `shift_en` is a one-clock pulse every 2×(c+1) input clocks while the display is enabled.
- R2: `hsync` is a one-clock pulse once per line. The line period is S × 2×(c+1) × (h+1) input clocks. S is 40 when the dot-width bit (address 1, bit 5) is 0 and 50 when it is 1. h is address 1, bits 4:0.
- R3: `vsync` is a one-clock pulse, coincident with an `hsync`, once per frame. The frame period is the line period × (V+B). V is the line count at address 2 and B is the blanking count at address 3.
- R4: When B is nonzero, `frame_irq` pulses for one clock once per frame, together with the `hsync` that ends line V−1. This is V line periods after `vsync`.
- R5: When B is zero, `frame_irq` never pulses.
- R6: `gray_level` is registered one clock after `pix_code`. Its encoding is white=0, gray3=1, gray2=2, gray1=3, black=4. Gradation mode (address 0, bits 5:4) 00 maps codes 0,1,2,3 to black, gray1, gray2, white. Mode 01 maps them to black, gray1, gray3, white. Mode 11 maps them to black, gray2, gray3, white.
- R7: Gradation mode 10 gives the same mapping as mode 00.
- R8: With the polarity bit (address 0, bit 0) set to 1, the output level n becomes 4−n.
- R9: With the enable bit (address 0, bit 7) at 0, no `shift_en`, `hsync`, `vsync` or `frame_irq` pulse appears. `gray_level` is then 0 when polarity is 0 and 4 when polarity is 1. After reset, all registers are zero.
- R10: Writes to clock select, dot width, horizontal count, V, B and the page bit (address 0, bit 6) made while enabled take effect only at the next frame boundary. `page_sel` changes in the same clock as that frame's `vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 horizontal, 2 line count, 3 blanking count |
| reg_wdata | input | 8 | Register write data |
| pix_code | input | 2 | Pixel code to be mapped |
| shift_en | output | 1 | Divided shift-clock enable |
| hsync | output | 1 | Line strobe |
| vsync | output | 1 | Frame strobe |
| frame_irq | output | 1 | Pulse on entry to the first blanking line |
| page_sel | output | 1 | Displayed page (0 = A, 1 = B) |
| gray_level | output | 3 | Gray level, 0 white to 4 black |

## Verification
The pulse-width and coincidence properties assume that every line lasts at least 80 input clocks, which holds for every legal register value. The line-range property assumes that V and B only change through the shadow reload, so the stimulus changes the timing fields while the display is off or in mid-frame and never forces internal state. Bits 7:6 of the horizontal register are always written as zero, and `pix_code` is always driven with a known value.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int REG_W  = 8;
    localparam int CSEL_W = 3;
    localparam int HTIM_W = 5;
    localparam int LINE_W = 8;
    localparam int LVL_W  = 3;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_HORIZ = 2'd1;
    localparam logic [1:0] ADDR_LINES = 2'd2;
    localparam logic [1:0] ADDR_BLANK = 2'd3;

    localparam logic [LVL_W-1:0] LVL_WHITE = 3'd0;
    localparam logic [LVL_W-1:0] LVL_GRAY3 = 3'd1;
    localparam logic [LVL_W-1:0] LVL_GRAY2 = 3'd2;
    localparam logic [LVL_W-1:0] LVL_GRAY1 = 3'd3;
    localparam logic [LVL_W-1:0] LVL_BLACK = 3'd4;

    typedef struct packed {
        logic              en;
        logic              page;
        logic [1:0]        grad;
        logic [CSEL_W-1:0] csel;
        logic              pol;
    } ctrl_t;

    typedef struct packed {
        logic [CSEL_W-1:0] csel;
        logic              wide;
        logic [HTIM_W-1:0] htim;
        logic [LINE_W-1:0] vlines;
        logic [LINE_W-1:0] vblank;
        logic              page;
    } timing_t;

    function automatic logic [LVL_W-1:0] grade_level(input logic [1:0] mode,
                                                     input logic [1:0] code,
                                                     input logic       pol);
        logic [LVL_W-1:0] n;
        case (code)
            2'd0:    n = LVL_BLACK;
            2'd1:    n = (mode == 2'b11) ? LVL_GRAY2 : LVL_GRAY1;
            2'd2:    n = (mode == 2'b01 || mode == 2'b11) ? LVL_GRAY3 : LVL_GRAY2;
            default: n = LVL_WHITE;
        endcase
        return pol ? (LVL_BLACK - n) : n;
    endfunction

endpackage

// File: rtl/lcd_reg_bank.sv
module lcd_reg_bank
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             frame_end,
    output ctrl_t            ctrl,
    output timing_t          timing
);

    localparam int HREG_W = HTIM_W + 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [HREG_W-1:0] hreg;
        logic [LINE_W-1:0] vlines;
        logic [LINE_W-1:0] vblank;
        timing_t           shadow;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (addr)
                ADDR_CTRL:  st_d.ctrl   = ctrl_t'(wdata);
                ADDR_HORIZ: st_d.hreg   = wdata[HREG_W-1:0];
                ADDR_LINES: st_d.vlines = wdata[LINE_W-1:0];
                default:    st_d.vblank = wdata[LINE_W-1:0];
            endcase
        end
        if (!st_q.ctrl.en || frame_end) begin
            st_d.shadow.csel   = st_q.ctrl.csel;
            st_d.shadow.wide   = st_q.hreg[HREG_W-1];
            st_d.shadow.htim   = st_q.hreg[HTIM_W-1:0];
            st_d.shadow.vlines = st_q.vlines;
            st_d.shadow.vblank = st_q.vblank;
            st_d.shadow.page   = st_q.ctrl.page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign timing = st_q.shadow;

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ctrl.en) && st_q.ctrl.en && !$past(frame_end)) |-> $stable(st_q.shadow));

endmodule

// File: rtl/lcd_clk_div.sv
module lcd_clk_div #(
    parameter int CSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CSEL_W-1:0] csel,
    output logic              tick
);

    localparam int DIV_W = CSEL_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic [DIV_W-1:0] lim;

    assign lim  = {csel, 1'b1};
    assign tick = run && (st_q.cnt == lim);

    always_comb begin
        st_d = st_q;
        if (!run)      st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= lim));

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/lcd_line_frame.sv
module lcd_line_frame #(
    parameter int DOTS_NARROW = 40,
    parameter int DOTS_WIDE   = 50,
    parameter int HTIM_W      = 5,
    parameter int LINE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wide,
    input  logic [HTIM_W-1:0] htim,
    input  logic [LINE_W-1:0] vlines,
    input  logic [LINE_W-1:0] vblank,
    output logic              hsync,
    output logic              vsync,
    output logic              irq,
    output logic              frame_end
);

    localparam int DOT_W = $clog2(DOTS_WIDE);
    localparam int TOT_W = LINE_W + 1;

    typedef struct packed {
        logic [DOT_W-1:0]  dot;
        logic [HTIM_W-1:0] hc;
        logic [TOT_W-1:0]  line;
        logic              hs;
        logic              vs;
        logic              irq;
    } lf_t;

    lf_t st_d, st_q;

    logic [DOT_W-1:0] dot_max;
    logic             dot_last, hc_last, line_end, last_line;
    logic [TOT_W-1:0] total, next_line;

    assign dot_max   = wide ? DOT_W'(DOTS_WIDE - 1) : DOT_W'(DOTS_NARROW - 1);
    assign dot_last  = (st_q.dot == dot_max);
    assign hc_last   = (st_q.hc == htim);
    assign line_end  = run && tick && dot_last && hc_last;
    assign total     = {1'b0, vlines} + {1'b0, vblank};
    assign last_line = ({1'b0, st_q.line} + 1'b1) >= {1'b0, total};
    assign next_line = last_line ? '0 : st_q.line + 1'b1;
    assign frame_end = line_end && last_line;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else begin
            if (tick) begin
                if (dot_last) begin
                    st_d.dot = '0;
                    st_d.hc  = hc_last ? '0 : st_q.hc + 1'b1;
                end else begin
                    st_d.dot = st_q.dot + 1'b1;
                end
            end
            if (line_end) st_d.line = next_line;
            st_d.hs  = line_end;
            st_d.vs  = frame_end;
            st_d.irq = line_end && (vblank != '0) && (next_line == {1'b0, vlines});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync = st_q.hs;
    assign vsync = st_q.vs;
    assign irq   = st_q.irq;

    // R2
    hsync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> !hsync);

    // R3
    vsync_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> hsync);

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total != '0) |-> (st_q.line < total));

    // R4
    irq_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hsync);

    // R5
    irq_needs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(vblank) != '0));

endmodule

// File: rtl/lcd_gray_map.sv
module lcd_gray_map
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             pol,
    input  logic [1:0]       code,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } gm_t;

    gm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable) st_d.lvl = grade_level(mode, code, pol);
        else        st_d.lvl = pol ? LVL_BLACK : LVL_WHITE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    // R6
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_BLACK);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int DOTS_NARROW = 40,
    parameter int DOTS_WIDE   = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [1:0]       pix_code,
    output logic             shift_en,
    output logic             hsync,
    output logic             vsync,
    output logic             frame_irq,
    output logic             page_sel,
    output logic [LVL_W-1:0] gray_level
);

    ctrl_t   ctrl;
    timing_t timing;
    logic    tick, frame_end;

    lcd_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .ctrl      (ctrl),
        .timing    (timing)
    );

    lcd_clk_div #(.CSEL_W(CSEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.en),
        .csel  (timing.csel),
        .tick  (tick)
    );

    lcd_line_frame #(
        .DOTS_NARROW (DOTS_NARROW),
        .DOTS_WIDE   (DOTS_WIDE),
        .HTIM_W      (HTIM_W),
        .LINE_W      (LINE_W)
    ) u_lf (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.en),
        .tick      (tick),
        .wide      (timing.wide),
        .htim      (timing.htim),
        .vlines    (timing.vlines),
        .vblank    (timing.vblank),
        .hsync     (hsync),
        .vsync     (vsync),
        .irq       (frame_irq),
        .frame_end (frame_end)
    );

    lcd_gray_map u_gray (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctrl.en),
        .mode   (ctrl.grad),
        .pol    (ctrl.pol),
        .code   (pix_code),
        .level  (gray_level)
    );

    assign shift_en = tick;
    assign page_sel = timing.page;

    // R9
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !$past(ctrl.en)) |-> !(hsync || vsync || frame_irq));

    // R2
    line_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> $past(shift_en));

endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [1:0] pix_code = 2'd0;
    logic       shift_en, hsync, vsync, frame_irq, page_sel;
    logic [2:0] gray_level;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_timing_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pix_code   (pix_code),
        .shift_en   (shift_en),
        .hsync      (hsync),
        .vsync      (vsync),
        .frame_irq  (frame_irq),
        .page_sel   (page_sel),
        .gray_level (gray_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_byte(input bit en, input bit page, input logic [1:0] grad,
                                             input int csel, input bit pol);
        return {en, page, grad, csel[2:0], pol};
    endfunction

    task automatic configure(input int csel, input bit wide, input int htim, input int v, input int b,
                             input bit page);
        wr(2'd0, ctrl_byte(1'b0, page, 2'b00, csel, 1'b0));
        wr(2'd1, {2'b00, wide, htim[4:0]});
        wr(2'd2, v[7:0]);
        wr(2'd3, b[7:0]);
        wr(2'd0, ctrl_byte(1'b1, page, 2'b00, csel, 1'b0));
    endtask

    function automatic bit sig(input int which);
        case (which)
            0: return shift_en;
            1: return hsync;
            2: return vsync;
            default: return frame_irq;
        endcase
    endfunction

    task automatic wait_pulse(input int which);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(which) && n < 20000);
    endtask

    task automatic gap(input int which, output int d);
        int t0;
        wait_pulse(which);
        t0 = cyc;
        wait_pulse(which);
        d = cyc - t0;
    endtask

    function automatic int model_level(input logic [1:0] mode, input int code, input bit pol);
        int n;
        case (code)
            0: n = 4;
            1: n = (mode == 2'b11) ? 2 : 3;
            2: n = (mode == 2'b01 || mode == 2'b11) ? 1 : 2;
            default: n = 0;
        endcase
        return pol ? 4 - n : n;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(shift_en == 1'b0 && hsync == 1'b0 && vsync == 1'b0 && frame_irq == 1'b0,
              "R9 reset strobes", {shift_en, hsync, vsync, frame_irq}, 0);
        check(page_sel == 1'b0, "R9 reset page", page_sel, 0);
        check(gray_level == 3'd0, "R9 reset gray", gray_level, 0);
    endtask

    task automatic t_divider();
        int d;
        int sels[3] = '{0, 2, 7};
        foreach (sels[i]) begin
            configure(sels[i], 1'b0, 0, 2, 1, 1'b0);
            gap(0, d);
            check(d == 2 * (sels[i] + 1), "R1 shift_en period", d, 2 * (sels[i] + 1));
        end
    endtask

    task automatic t_line();
        int d;
        configure(0, 1'b0, 0, 2, 1, 1'b0);
        gap(1, d);
        check(d == 80, "R2 line narrow", d, 80);
        configure(1, 1'b1, 1, 2, 1, 1'b0);
        gap(1, d);
        check(d == 400, "R2 line wide div4 h1", d, 400);
        configure(0, 1'b1, 0, 2, 1, 1'b0);
        gap(1, d);
        check(d == 100, "R2 line wide", d, 100);
    endtask

    task automatic t_frame();
        int d, t0;
        configure(0, 1'b0, 0, 3, 2, 1'b0);
        gap(2, d);
        check(d == 400, "R3 frame period", d, 400);
        gap(3, d);
        check(d == 400, "R4 irq period", d, 400);
        check(hsync == 1'b1, "R4 irq with hsync", hsync, 1);
        wait_pulse(2);
        t0 = cyc;
        wait_pulse(3);
        check(cyc - t0 == 240, "R4 irq after V lines", cyc - t0, 240);
    endtask

    task automatic t_noblank();
        int d, cnt = 0;
        configure(0, 1'b0, 0, 4, 0, 1'b0);
        gap(2, d);
        check(d == 320, "R3 frame no blank", d, 320);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (frame_irq) cnt++;
        end
        check(cnt == 0, "R5 no irq without blanking", cnt, 0);
    endtask

    task automatic t_gray();
        logic [1:0] modes[4] = '{2'b00, 2'b01, 2'b11, 2'b10};
        configure(0, 1'b0, 0, 2, 1, 1'b0);
        for (int p = 0; p < 2; p++) begin
            foreach (modes[m]) begin
                wr(2'd0, ctrl_byte(1'b1, 1'b0, modes[m], 0, p[0]));
                for (int c = 0; c < 4; c++) begin
                    int e;
                    pix_code = c[1:0];
                    @(negedge clk);
                    e = model_level(modes[m], c, p[0]);
                    if (modes[m] == 2'b10)
                        check(gray_level == e, "R7 reserved mode", gray_level, e);
                    else if (p != 0)
                        check(gray_level == e, "R8 polarity", gray_level, e);
                    else
                        check(gray_level == e, "R6 gradation", gray_level, e);
                end
            end
        end
    endtask

    task automatic t_disabled();
        int cnt = 0;
        configure(0, 1'b0, 0, 2, 1, 1'b0);
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 2'b00, 0, 1'b0));
        pix_code = 2'd0;
        @(negedge clk);
        check(gray_level == 3'd0, "R9 off gray white", gray_level, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (shift_en || hsync || vsync || frame_irq) cnt++;
        end
        check(cnt == 0, "R9 no strobes when off", cnt, 0);
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 2'b00, 0, 1'b1));
        @(negedge clk);
        check(gray_level == 3'd4, "R9 off gray black", gray_level, 4);
    endtask

    task automatic t_shadow();
        int d, t0;
        configure(0, 1'b0, 0, 3, 2, 1'b0);
        wait_pulse(2);
        wait_pulse(1);
        wr(2'd1, 8'h01);
        wr(2'd0, ctrl_byte(1'b1, 1'b1, 2'b00, 0, 1'b0));
        gap(1, d);
        check(d == 80, "R10 line unchanged mid-frame", d, 80);
        check(page_sel == 1'b0, "R10 page held mid-frame", page_sel, 0);
        wait_pulse(2);
        t0 = cyc;
        check(page_sel == 1'b1, "R10 page at vsync", page_sel, 1);
        wait_pulse(1);
        check(cyc - t0 == 160, "R10 new line after boundary", cyc - t0, 160);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_line();
        t_frame();
        t_noblank();
        t_gray();
        t_disabled();
        t_shadow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule